// File: doc/BRIEF.md
# Gap-Width Transponder Write Serializer

This block sends one programming frame to a low-frequency transponder by switching the reader field on and off. A single output level controls the field, and a high level means the field is on. A start strobe accepted while the block is idle captures a 64-bit identifier and a check word. The block then turns the field on for a charge interval and sends 14 bytes. Each bit occupies a fixed slot. The bit value is carried only by how long the field is switched off at the start of the slot, and the field is back on for the rest of the slot. After the last slot the field stays on for a programming hold. The block then drops the field, clears busy and gives a one-cycle done pulse.

A selector input chooses the check word. It is either the word presented on the port, sent unchanged, or a CRC-16 that the block computes over the identifier. Every time in the frame is a whole number of microseconds. A prescaler derives a microsecond tick from the clock, with `CLK_PER_US` cycles per tick. The charge, gap, slot and hold lengths are parameters given in microseconds, so every timing in the frame is an exact cycle count.

States: `ST_IDLE` (field off, waiting), `ST_CHARGE` (field on before the first bit), `ST_GAP` (field off, 1 or 0 gap length), `ST_MARK` (field on for the rest of the slot) and `ST_PROG` (field on for the programming hold). Transitions:
- idle→charge when start is accepted.
- charge→gap when the charge time expires.
- gap→mark when the gap expires.
- mark→gap when the slot ends and bits remain.
- mark→prog when the slot of the final bit ends.
- prog→idle when the hold expires; this transition also raises done.

Top module: `lf_field_writer`

## Requirements
- R1: While idle, which includes after reset and after a completed frame, `field_on_o`, `busy_o` and `done_o` are low.
- R2: A high `start_i` sampled while idle sets `busy_o` and `field_on_o` from the next cycle. The field stays on for exactly CHARGE_US*CLK_PER_US cycles before the first gap.
- R3: A 1 bit is a field-off gap of ONE_GAP_US*CLK_PER_US cycles, followed by field-on for (SLOT_US-ONE_GAP_US)*CLK_PER_US cycles.
- R4: A 0 bit is a field-off gap of ZERO_GAP_US*CLK_PER_US cycles, followed by field-on for (SLOT_US-ZERO_GAP_US)*CLK_PER_US cycles.
- R5: The frame has 14 bytes sent in this order: 0xBB, 0xEB, the eight identifier bytes from bits [7:0] up to bits [63:56], check word bits [7:0], check word bits [15:8], 0x00, 0x03.
- R6: Within each byte, bit 0 is sent first and bit 7 last.
- R7: After the final bit the field stays on for PROG_US*CLK_PER_US cycles beyond the end of that bit's slot, and then goes off.
- R8: `done_o` is high for exactly one cycle. That cycle is the first one in which `field_on_o` and `busy_o` are low after the hold.
- R9: With `crc_given_i`=1 at start, the check word sent is `crc_i` exactly as given, even if it is not a valid CRC.
- R10: With `crc_given_i`=0 at start, the check word is a CRC-16 over the eight identifier bytes, taken from byte [7:0] up to byte [63:56]. The CRC uses polynomial 0x1021 and initial value 0x0000, and each byte enters MSB first.
- R11: A start strobe while busy is ignored. The frame in progress and its timing are unchanged, and no new frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Frame request, taken only while idle |
| id_i | input | 64 | Identifier, captured at start |
| crc_i | input | 16 | Check word to send when `crc_given_i` is set |
| crc_given_i | input | 1 | 1: send `crc_i`; 0: send the computed CRC |
| field_on_o | output | 1 | Reader field enable, high means on |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the frame completes |

## Verification
The assertions assume that the timing parameters keep the zero gap shorter than the one gap, and the one gap shorter than the slot. They also assume that `id_i`, `crc_i` and `crc_given_i` matter only in the cycle a start is accepted. The stimulus drives start for one cycle, away from the clock edge. During a running frame it changes the identifier and strobes start, and the checks confirm that the output waveform still matches the captured request. Expected bytes and CRC values are rebuilt in the bench with a bit-serial CRC over the identifier. Each field-off and field-on run is measured in cycles against the parameter products.

// File: rtl/lf_wr_pkg.sv
package lf_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHARGE,
        ST_GAP,
        ST_MARK,
        ST_PROG
    } wr_state_e;

    localparam int FRAME_BYTES = 14;
    localparam int BYTE_IDX_W  = 4;
    localparam int DATA_BYTES  = 8;

    localparam logic [7:0] HDR_KEY   = 8'hBB;
    localparam logic [7:0] HDR_PASS  = 8'hEB;
    localparam logic [7:0] TRL_LOW   = 8'h00;
    localparam logic [7:0] TRL_HIGH  = 8'h03;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'h0000;

endpackage

// File: rtl/lf_us_tick.sv
module lf_us_tick #(
    parameter int CLK_PER_US = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/lf_crc16_calc.sv
module lf_crc16_calc
    import lf_wr_pkg::*;
(
    input  logic [63:0] id_i,
    output logic [15:0] crc_o
);
    always_comb begin
        logic [15:0] acc;
        acc = CRC_INIT;
        for (int k = 0; k < DATA_BYTES; k++) begin
            acc = acc ^ {id_i[8*k +: 8], 8'h00};
            for (int b = 0; b < 8; b++) begin
                if (acc[15]) acc = (acc << 1) ^ CRC_POLY;
                else         acc = acc << 1;
            end
        end
        crc_o = acc;
    end
endmodule

// File: rtl/lf_frame_byte_sel.sv
module lf_frame_byte_sel
    import lf_wr_pkg::*;
(
    input  logic [BYTE_IDX_W-1:0] idx_i,
    input  logic [63:0]           id_i,
    input  logic [15:0]           crc_i,
    output logic [7:0]            byte_o
);
    logic [7:0] frame [FRAME_BYTES];

    assign frame[0] = HDR_KEY;
    assign frame[1] = HDR_PASS;

    for (genvar k = 0; k < DATA_BYTES; k++) begin : g_data
        assign frame[2 + k] = id_i[8*k +: 8];
    end

    assign frame[10] = crc_i[7:0];
    assign frame[11] = crc_i[15:8];
    assign frame[12] = TRL_LOW;
    assign frame[13] = TRL_HIGH;

    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < FRAME_BYTES; k++) begin
            if (idx_i == BYTE_IDX_W'(k)) byte_o = frame[k];
        end
    end
endmodule

// File: rtl/lf_field_writer.sv
module lf_field_writer
    import lf_wr_pkg::*;
#(
    parameter int CLK_PER_US  = 24,
    parameter int CHARGE_US   = 50000,
    parameter int SLOT_US     = 2000,
    parameter int ONE_GAP_US  = 1000,
    parameter int ZERO_GAP_US = 300,
    parameter int PROG_US     = 15000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] id_i,
    input  logic [15:0] crc_i,
    input  logic        crc_given_i,
    output logic        field_on_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam int MAX_A  = (CHARGE_US > SLOT_US) ? CHARGE_US : SLOT_US;
    localparam int MAX_US = (MAX_A > PROG_US) ? MAX_A : PROG_US;
    localparam int UW     = $clog2(MAX_US + 1);

    localparam logic [UW-1:0] D_CHARGE = UW'(CHARGE_US);
    localparam logic [UW-1:0] D_GAP1   = UW'(ONE_GAP_US);
    localparam logic [UW-1:0] D_GAP0   = UW'(ZERO_GAP_US);
    localparam logic [UW-1:0] D_MARK1  = UW'(SLOT_US - ONE_GAP_US);
    localparam logic [UW-1:0] D_MARK0  = UW'(SLOT_US - ZERO_GAP_US);
    localparam logic [UW-1:0] D_PROG   = UW'(PROG_US);
    localparam logic [BYTE_IDX_W-1:0] LAST_BYTE = BYTE_IDX_W'(FRAME_BYTES - 1);

    wr_state_e state_q, state_d;

    logic [63:0]           id_q;
    logic [15:0]           crc_q;
    logic [15:0]           crc_calc;
    logic [BYTE_IDX_W-1:0] byte_idx_q;
    logic [2:0]            bit_idx_q;
    logic [UW-1:0]         ucnt_q;
    logic [UW-1:0]         dur;
    logic [7:0]            cur_byte;
    logic                  cur_bit;
    logic                  tick;
    logic                  seg_end;
    logic                  accept;
    logic                  last_bit;
    logic                  done_q;

    lf_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .tick_o (tick)
    );

    lf_crc16_calc u_crc (
        .id_i  (id_i),
        .crc_o (crc_calc)
    );

    lf_frame_byte_sel u_sel (
        .idx_i  (byte_idx_q),
        .id_i   (id_q),
        .crc_i  (crc_q),
        .byte_o (cur_byte)
    );

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign cur_bit  = cur_byte[bit_idx_q];
    assign last_bit = (byte_idx_q == LAST_BYTE) && (bit_idx_q == 3'd7);

    always_comb begin
        unique case (state_q)
            ST_CHARGE: dur = D_CHARGE;
            ST_GAP:    dur = cur_bit ? D_GAP1 : D_GAP0;
            ST_MARK:   dur = cur_bit ? D_MARK1 : D_MARK0;
            ST_PROG:   dur = D_PROG;
            default:   dur = D_CHARGE;
        endcase
    end

    assign seg_end = (state_q != ST_IDLE) && tick && (ucnt_q == dur - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CHARGE;
            ST_CHARGE: if (seg_end) state_d = ST_GAP;
            ST_GAP:    if (seg_end) state_d = ST_MARK;
            ST_MARK:   if (seg_end) state_d = last_bit ? ST_PROG : ST_GAP;
            ST_PROG:   if (seg_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q       <= '0;
            crc_q      <= '0;
            byte_idx_q <= '0;
            bit_idx_q  <= '0;
            ucnt_q     <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= (state_q == ST_PROG) && seg_end;
            if (accept) begin
                id_q       <= id_i;
                crc_q      <= crc_given_i ? crc_i : crc_calc;
                byte_idx_q <= '0;
                bit_idx_q  <= '0;
                ucnt_q     <= '0;
            end else if (seg_end) begin
                ucnt_q <= '0;
                if (state_q == ST_MARK && !last_bit) begin
                    bit_idx_q <= bit_idx_q + 1'b1;
                    if (bit_idx_q == 3'd7) byte_idx_q <= byte_idx_q + 1'b1;
                end
            end else if (tick && state_q != ST_IDLE) begin
                ucnt_q <= ucnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_CHARGE, ST_MARK, ST_PROG: field_on_o = 1'b1;
            default:                     field_on_o = 1'b0;
        endcase
        busy_o = (state_q != ST_IDLE);
        done_o = done_q;
    end
endmodule

// File: rtl/lf_field_writer_chk.sv
module lf_field_writer_chk #(
    parameter int CLK_PER_US = 24,
    parameter int ONE_GAP_US = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic field_on_o,
    input logic busy_o,
    input logic done_o
);
    localparam int GAP_LIMIT = ONE_GAP_US * CLK_PER_US;

    int low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                   low_cnt <= 0;
        else if (busy_o && !field_on_o) low_cnt <= low_cnt + 1;
        else                          low_cnt <= 0;
    end

    a_r1_idle_field_off: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !field_on_o);

    a_r2_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (field_on_o && $past(start_i)));

    a_r3_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !field_on_o) |-> (low_cnt < GAP_LIMIT));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !field_on_o && $past(busy_o)));

    a_r7_hold_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(field_on_o));
endmodule

bind lf_field_writer lf_field_writer_chk #(
    .CLK_PER_US (CLK_PER_US),
    .ONE_GAP_US (ONE_GAP_US)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .field_on_o (field_on_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/sim_lf_field_writer.sv
module sim_lf_field_writer;
    localparam int CPU   = 2;
    localparam int CHG   = 20;
    localparam int SLOT  = 10;
    localparam int GAP1  = 5;
    localparam int GAP0  = 2;
    localparam int PROG  = 15;
    localparam int NBITS = 112;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] id_i = '0;
    logic [15:0] crc_i = '0;
    logic        crc_given_i = 1'b0;
    logic        field_on_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int hi_run [0:NBITS];
    int lo_run [0:NBITS-1];
    logic [7:0] exp_b [0:13];
    logic [7:0] rx_b  [0:13];

    always #5 clk = ~clk;

    lf_field_writer #(
        .CLK_PER_US (CPU), .CHARGE_US (CHG), .SLOT_US (SLOT),
        .ONE_GAP_US (GAP1), .ZERO_GAP_US (GAP0), .PROG_US (PROG)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .id_i (id_i),
        .crc_i (crc_i), .crc_given_i (crc_given_i),
        .field_on_o (field_on_o), .busy_o (busy_o), .done_o (done_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [63:0] id);
        logic [15:0] c = 16'h0000;
        for (int k = 0; k < 8; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[15] ^ id[8*k + b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic build_expected(input logic [63:0] id, input logic [15:0] cw);
        exp_b[0] = 8'hBB;
        exp_b[1] = 8'hEB;
        for (int k = 0; k < 8; k++) exp_b[2+k] = id[8*k +: 8];
        exp_b[10] = cw[7:0];
        exp_b[11] = cw[15:8];
        exp_b[12] = 8'h00;
        exp_b[13] = 8'h03;
    endtask

    task automatic capture_frame();
        for (int r = 0; r < 2*NBITS + 1; r++) begin
            logic lvl = (r % 2 == 0);
            int cnt = 0;
            while (field_on_o == lvl && cnt < 5000) begin
                cnt++;
                @(negedge clk);
            end
            if (lvl) hi_run[r/2] = cnt;
            else     lo_run[r/2] = cnt;
        end
    endtask

    task automatic pulse_start(input logic [63:0] id, input logic [15:0] cw, input logic given);
        @(negedge clk);
        id_i = id; crc_i = cw; crc_given_i = given; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Checks waveform against exp_b; must be called right after capture_frame.
    task automatic check_frame(input string tag);
        int bad1 = 0, bad0 = 0, badshape = 0;
        chk({tag, " R2 charge"}, hi_run[0], CHG*CPU);
        for (int n = 0; n < NBITS; n++) begin
            logic b = exp_b[n/8][n%8];
            int gexp = b ? GAP1*CPU : GAP0*CPU;
            int hexp = (b ? SLOT-GAP1 : SLOT-GAP0)*CPU + ((n == NBITS-1) ? PROG*CPU : 0);
            if (lo_run[n] == GAP1*CPU)      rx_b[n/8][n%8] = 1'b1;
            else if (lo_run[n] == GAP0*CPU) rx_b[n/8][n%8] = 1'b0;
            else                            badshape++;
            if (n < NBITS-1) begin
                if (b && (lo_run[n] != gexp || hi_run[n+1] != hexp)) bad1++;
                if (!b && (lo_run[n] != gexp || hi_run[n+1] != hexp)) bad0++;
            end
        end
        chk({tag, " R3 one-bit shape mismatches"}, bad1, 0);
        chk({tag, " R4 zero-bit shape mismatches"}, bad0, 0);
        chk({tag, " R3/R4 gap widths"}, badshape, 0);
        for (int k = 0; k < 14; k++) chk({tag, " R5 frame byte"}, rx_b[k], exp_b[k]);
        chk({tag, " R7 last mark plus hold"}, hi_run[NBITS],
            (exp_b[13][7] ? SLOT-GAP1 : SLOT-GAP0)*CPU + PROG*CPU);
        chk({tag, " R8 done at first idle"}, {done_o, busy_o, field_on_o}, 3'b100);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, done_o, 0);
        repeat (20) @(negedge clk);
        chk({tag, " R1 field off after done"}, {field_on_o, busy_o, done_o}, 3'b000);
    endtask

    task automatic t_reset();
        chk("R1 reset state", {field_on_o, busy_o, done_o}, 3'b000);
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 idle without start", {field_on_o, busy_o}, 2'b00);
    endtask

    task automatic t_supplied_crc();
        logic [63:0] id = 64'h0123_4567_89AB_CDEF;
        pulse_start(id, 16'hDEAD, 1'b1);
        chk("R2 busy after start", busy_o, 1);
        build_expected(id, 16'hDEAD);
        capture_frame();
        check_frame("supplied");
        chk("R9 crc verbatim", {rx_b[11], rx_b[10]}, 16'hDEAD);
        // R6: keyword 0xBB sent bit 0 first: gaps 1,1,0,1,1,1,0,1
        chk("R6 lsb first keyword", {lo_run[7] == GAP1*CPU, lo_run[6] == GAP1*CPU,
            lo_run[5] == GAP1*CPU, lo_run[4] == GAP1*CPU, lo_run[3] == GAP1*CPU,
            lo_run[2] == GAP1*CPU, lo_run[1] == GAP1*CPU, lo_run[0] == GAP1*CPU}, 8'hBB);
    endtask

    task automatic t_computed_crc(input logic [63:0] id, input string tag);
        logic [15:0] c = ref_crc(id);
        pulse_start(id, 16'h5A5A, 1'b0);
        build_expected(id, c);
        capture_frame();
        check_frame(tag);
        chk({tag, " R10 computed crc"}, {rx_b[11], rx_b[10]}, c);
    endtask

    task automatic t_busy_ignore();
        logic [63:0] id = 64'hFEDC_BA98_7654_3210;
        pulse_start(id, 16'h1234, 1'b1);
        build_expected(id, 16'h1234);
        fork
            capture_frame();
            begin
                repeat (300) @(negedge clk);
                id_i = 64'h0; crc_i = 16'hFFFF; start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                repeat (900) @(negedge clk);
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end
        join
        check_frame("R11 busy");
        chk("R11 no second frame", busy_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_supplied_crc();
        t_computed_crc(64'h3837_3635_3433_3231, "ascii");
        t_computed_crc(64'h0, "zeros");
        t_computed_crc(64'hFFFF_FFFF_FFFF_FFFF, "ones");
        t_busy_ignore();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule